// File: doc/BRIEF.md
# Two-Phase PDM Microphone Array Capture

This block reads a planar array of 64 one-bit PDM microphones over only 32 data pins. It produces one shared microphone clock, and each data pin is shared by two microphones. One microphone drives the pin while the clock is high. The other drives it while the clock is low. The block samples each pin at the last system-clock cycle of each half period. At the end of every microphone clock period it packs all 64 current bits into one word and offers that word on a valid/ready stream.

The microphone clock comes from an integer divider of the system clock. Its half-period length is programmable and is taken when capture starts. Several array modules can run in lockstep. One module is the master and starts as soon as it is enabled, pulsing a sync output. The other modules are slaves: they wait, while enabled, for that pulse on their sync input. After each start, a programmable number of words is dropped so that the microphones can settle. A word that arrives while the stream is stalled is lost, and a sticky flag records the loss.

Top module: `pdm_array_capture`

## Requirements
- R1: After reset, `pdm_clk`, `sync_out`, `out_valid` and `overflow` are all 0.
- R2: While running, `pdm_clk` is high for H system cycles and then low for H cycles. H is `cfg_half` as sampled at the start cycle, and a value of 0 is treated as 1.
- R3: In each emitted word, bit 2j holds line j as sampled in the last high cycle of that period, and bit 2j+1 holds line j as sampled in the last low cycle.
- R4: Exactly one word is produced per `pdm_clk` period. It is visible from the cycle after the last low cycle. While `out_ready` is 0, `out_valid` and `out_data` hold steady.
- R5: A word that completes while `out_valid`=1 and `out_ready`=0 is dropped and sets `overflow`. `overflow` then stays 1 until reset, and it is not set while no word has been dropped.
- R6: After each start, the first `cfg_skip` words are discarded. With `cfg_skip`=0, the first word of the first period is emitted.
- R7: A master (`is_master`=1) starts on the first clock edge at which `enable` is seen high. `sync_out` is a one-cycle pulse in the first high cycle of `pdm_clk`.
- R8: A slave (`is_master`=0) that is enabled keeps `pdm_clk` low and emits nothing until it sees `sync_in`=1. It then starts on that edge.
- R9: When `enable` is 0, `pdm_clk` is held low. A later start restarts the period count and the skip count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Capture enable |
| is_master | input | 1 | 1 = start on enable, 0 = wait for sync_in |
| sync_in | input | 1 | Start pulse from the master module |
| cfg_half | input | 8 | Half period of pdm_clk in system cycles |
| cfg_skip | input | 8 | Number of words to discard after a start |
| pdm_data | input | 32 | Shared microphone data lines |
| pdm_clk | output | 1 | Common microphone clock |
| sync_out | output | 1 | Start pulse for slave modules |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 64 | Packed word, one bit per microphone |
| overflow | output | 1 | Sticky word-loss flag |

## Verification
The phase counter drives the clock, both sample strobes and the word timing. A counter that is off by one shows up as wrong high or low run lengths on `pdm_clk` within a single period. It also shows as even and odd bits that come from the wrong phase in the very first emitted word. A skip counter or stream state that goes wrong shows at the ports in one of two ways: a first word that belongs to the wrong period, or an `out_data` that changes while the stream is stalled. A bad start condition is visible within a few cycles of `enable` or `sync_in`, through a missing or extra `pdm_clk` edge or a misplaced `sync_out`.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;
  localparam int CFG_MAX_W = 16;
  typedef logic [CFG_MAX_W-1:0] cfg_t;

  // effective half period: zero is promoted to one
  function automatic cfg_t eff_half(input cfg_t h);
    return (h == '0) ? cfg_t'(1) : h;
  endfunction

  // index of the last system cycle in one microphone clock period
  function automatic logic [CFG_MAX_W:0] period_last(input cfg_t h);
    return {1'b0, eff_half(h)} + {1'b0, eff_half(h)} - 1'b1;
  endfunction
endpackage

// File: rtl/pdm_phase_gen.sv
module pdm_phase_gen
  import pdm_cap_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              is_master,
  input  logic              sync_in,
  input  logic [HALF_W-1:0] cfg_half,
  output logic              run,
  output logic              start,
  output logic              pdm_clk,
  output logic              strobe_hi,
  output logic              strobe_lo,
  output logic              sync_out
);
  localparam int CW = HALF_W + 1;

  logic [CW-1:0]     cnt;
  logic [HALF_W-1:0] half_q;
  logic [CW-1:0]     last;
  logic [CW-1:0]     half_ext;

  assign half_ext = {1'b0, half_q};
  assign last     = CW'(period_last(cfg_t'(half_q)));
  assign start    = enable && !run && (is_master || sync_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      cnt      <= '0;
      half_q   <= HALF_W'(1);
      sync_out <= 1'b0;
    end else begin
      sync_out <= start && is_master;
      if (!enable) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (start) begin
        run    <= 1'b1;
        cnt    <= '0;
        half_q <= HALF_W'(eff_half(cfg_t'(cfg_half)));
      end else if (run) begin
        cnt <= (cnt == last) ? '0 : cnt + 1'b1;
      end
    end
  end

  assign pdm_clk   = run && (cnt < half_ext);
  assign strobe_hi = run && (cnt == half_ext - CW'(1));
  assign strobe_lo = run && (cnt == last);

  AST_FALL_AFTER_HI: assert property (@(posedge clk) disable iff (rst)
    strobe_hi && enable |=> !pdm_clk); // R2
  AST_RISE_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
    strobe_lo && enable |=> pdm_clk); // R2
  AST_CLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pdm_clk); // R9
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (rst)
    sync_out |=> !sync_out); // R7
  AST_SLAVE_WAIT: assert property (@(posedge clk) disable iff (rst)
    !run && !is_master && !sync_in |=> !pdm_clk); // R8
endmodule

// File: rtl/pdm_lane_pack.sv
module pdm_lane_pack #(
  parameter int LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe_hi,
  input  logic [LINES-1:0]   pdm_data,
  output logic [2*LINES-1:0] word
);
  logic [LINES-1:0] hi_q;

  for (genvar j = 0; j < LINES; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) hi_q[j] <= 1'b0;
      else if (strobe_hi) hi_q[j] <= pdm_data[j];
    end
    // microphone on the high phase -> even bit, low phase -> odd bit
    assign word[2*j]   = hi_q[j];
    assign word[2*j+1] = pdm_data[j];
  end
endmodule

// File: rtl/pdm_word_stream.sv
module pdm_word_stream #(
  parameter int WORD_W = 64,
  parameter int SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              overflow
);
  logic [SKIP_W-1:0] skip_cnt;
  logic skipping, take, stalled;

  assign skipping = (skip_cnt != '0);
  assign take     = word_done && !skipping;
  assign stalled  = out_valid && !out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_cnt  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (start) skip_cnt <= cfg_skip;
      else if (word_done && skipping) skip_cnt <= skip_cnt - 1'b1;

      if (take && !stalled) begin
        out_data  <= word_in;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end

      if (take && stalled) overflow <= 1'b1;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    stalled |=> out_valid && $stable(out_data)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R5
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(out_valid) && !$past(out_ready)); // R5
  AST_SKIP_DROP: assert property (@(posedge clk) disable iff (rst)
    word_done && skipping |=> $stable(out_data) && !$rose(out_valid)); // R6
endmodule

// File: rtl/pdm_array_capture.sv
module pdm_array_capture #(
  parameter int LINES  = 32,
  parameter int HALF_W = 8,
  parameter int SKIP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 is_master,
  input  logic                 sync_in,
  input  logic [HALF_W-1:0]    cfg_half,
  input  logic [SKIP_W-1:0]    cfg_skip,
  input  logic [LINES-1:0]     pdm_data,
  output logic                 pdm_clk,
  output logic                 sync_out,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*LINES-1:0]   out_data,
  output logic                 overflow
);
  localparam int WORD_W = 2 * LINES;

  logic run, start, strobe_hi, strobe_lo, word_done;
  logic [WORD_W-1:0] word;

  pdm_phase_gen #(.HALF_W(HALF_W)) u_phase (
    .clk(clk), .rst(rst), .enable(enable), .is_master(is_master),
    .sync_in(sync_in), .cfg_half(cfg_half), .run(run), .start(start),
    .pdm_clk(pdm_clk), .strobe_hi(strobe_hi), .strobe_lo(strobe_lo),
    .sync_out(sync_out)
  );

  pdm_lane_pack #(.LINES(LINES)) u_pack (
    .clk(clk), .rst(rst), .strobe_hi(strobe_hi), .pdm_data(pdm_data),
    .word(word)
  );

  assign word_done = strobe_lo;

  pdm_word_stream #(.WORD_W(WORD_W), .SKIP_W(SKIP_W)) u_stream (
    .clk(clk), .rst(rst), .start(start), .cfg_skip(cfg_skip),
    .word_done(word_done), .word_in(word), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .overflow(overflow)
  );

  AST_ONE_WORD_PER_PERIOD: assert property (@(posedge clk) disable iff (rst)
    word_done |-> !strobe_hi && run); // R4
  AST_IDLE_NO_WORD: assert property (@(posedge clk) disable iff (rst)
    !run |-> !word_done && !pdm_clk); // R9
endmodule

// File: tb/pdm_array_capture_tb.sv
module pdm_array_capture_tb;
  logic clk = 0;
  logic rst, enable, is_master, sync_in, out_ready;
  logic [7:0] cfg_half, cfg_skip;
  logic [31:0] pdm_data;
  logic pdm_clk, sync_out, out_valid, overflow;
  logic [63:0] out_data;

  int n_checks = 0, n_fail = 0;
  int pidx;
  logic prev_clk;

  always #10 clk = ~clk;

  pdm_array_capture u_dut (
    .clk(clk), .rst(rst), .enable(enable), .is_master(is_master),
    .sync_in(sync_in), .cfg_half(cfg_half), .cfg_skip(cfg_skip),
    .pdm_data(pdm_data), .pdm_clk(pdm_clk), .sync_out(sync_out),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .overflow(overflow)
  );

  // per period: upper half = lines during high phase, lower = low phase
  localparam logic [63:0] VEC [8] = '{
    64'h00000000_FFFFFFFF, 64'hFFFFFFFF_00000000,
    64'hAAAAAAAA_55555555, 64'h12345678_9ABCDEF0,
    64'h80000001_7FFFFFFE, 64'hDEADBEEF_0F0F0F0F,
    64'h00000000_00000000, 64'hFFFFFFFF_FFFFFFFF };

  function automatic logic [63:0] expect_word(input int p);
    logic [63:0] w;
    logic [31:0] a, b;
    a = VEC[p % 8][63:32];
    b = VEC[p % 8][31:0];
    for (int j = 0; j < 32; j++) begin
      w[2*j]   = a[j];
      w[2*j+1] = b[j];
    end
    return w;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // microphone model: drives the phase's data while pdm_clk is in it
  initial begin
    pidx = -1; prev_clk = 0; pdm_data = '0;
    forever begin
      @(negedge clk);
      if (pdm_clk && !prev_clk) pidx++;
      prev_clk = pdm_clk;
      if (pidx >= 0)
        pdm_data = pdm_clk ? VEC[pidx % 8][63:32] : VEC[pidx % 8][31:0];
    end
  end

  task automatic restart_mics();
    @(posedge clk);
    pidx = -1; prev_clk = 0;
  endtask

  task automatic wait_word(output logic [63:0] w, input string req);
    bit got = 0;
    w = '0;
    for (int i = 0; i < 400 && !got; i++) begin
      @(negedge clk); #1;
      if (out_valid) begin got = 1; w = out_data; end
    end
    if (!got) check(0, req, 64'd0, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [63:0] w, w1;
    int hc, lc, bad;
    rst = 1; enable = 0; is_master = 1; sync_in = 0; out_ready = 1;
    cfg_half = 8'd2; cfg_skip = 8'd2;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    check(!pdm_clk && !sync_out && !out_valid && !overflow, "R1",
          {pdm_clk, sync_out, out_valid, overflow}, 4'b0);
    rst = 0;

    // master start, half=2, skip=2
    restart_mics();
    @(negedge clk); #1; enable = 1;
    @(negedge clk); #1;
    check(pdm_clk && sync_out, "R7 start+sync", {pdm_clk, sync_out}, 2'b11);
    @(negedge clk); #1;
    check(!sync_out, "R7 one-cycle sync", sync_out, 0);
    // vector walk: words from periods 2..7 (R3, R4, R6)
    for (int k = 0; k < 6; k++) begin
      wait_word(w, "R4 word");
      check(w == expect_word(k + 2), "R3/R6 packed word", w, expect_word(k + 2));
    end

    // stop, reconfigure half=3 skip=0, restart (R9)
    @(negedge clk); #1; enable = 0;
    repeat (3) @(negedge clk); #1;
    check(!pdm_clk, "R9 disabled clock low", pdm_clk, 0);
    cfg_half = 8'd3; cfg_skip = 8'd0;
    restart_mics();
    @(negedge clk); #1; enable = 1;
    wait_word(w, "R4 word");
    check(w == expect_word(0), "R6/R9 first word after restart", w, expect_word(0));
    hc = 1;
    forever begin @(negedge clk); #1; if (pdm_clk) hc++; else break; end
    lc = 1;
    forever begin @(negedge clk); #1; if (!pdm_clk) lc++; else break; end
    check(hc == 3, "R2 high length", hc, 3);
    check(lc == 3, "R2 low length", lc, 3);

    // stall the stream (R4, R5)
    out_ready = 0;
    wait_word(w1, "R4 word");
    check(!overflow, "R5 no overflow before drop", overflow, 0);
    repeat (24) @(negedge clk); #1;
    check(overflow, "R5 overflow set", overflow, 1);
    check(out_valid && out_data == w1, "R4 held word", out_data, w1);
    out_ready = 1;
    repeat (3) @(negedge clk); #1;
    check(overflow, "R5 overflow sticky", overflow, 1);

    // disabled: clock stays low (R9), reset clears (R1)
    enable = 0;
    @(negedge clk); #1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); #1; if (pdm_clk) bad++; end
    check(bad == 0, "R9 idle clock", bad, 0);
    rst = 1;
    @(negedge clk); #1; rst = 0;
    @(negedge clk); #1;
    check(!overflow && !out_valid, "R1 reset clears", {overflow, out_valid}, 2'b0);

    // slave mode (R8), half=2 skip=1
    is_master = 0; cfg_half = 8'd2; cfg_skip = 8'd1;
    restart_mics();
    @(negedge clk); #1; enable = 1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (pdm_clk || out_valid || sync_out) bad++;
    end
    check(bad == 0, "R8 slave waits", bad, 0);
    sync_in = 1;
    @(negedge clk); #1; sync_in = 0;
    check(pdm_clk && !sync_out, "R8 slave starts on sync", {pdm_clk, sync_out}, 2'b10);
    wait_word(w, "R8 word");
    check(w == expect_word(1), "R8/R6 slave first word", w, expect_word(1));

    summary();
  end
endmodule